// File: doc/BRIEF.md
# Peripheral Module Clock Controller

This block derives a clock-enable strobe for one peripheral from the system clock. Software programs it through a single 32-bit control word. An 8-bit divisor sets the strobe rate, and a divisor of zero turns the peripheral off. Two request inputs can stop the strobe:

- A sleep request stops it unless software has told the block to disregard sleep.
- A debug suspend request stops it only when software has allowed suspension.

When a suspend stops the strobe, software chooses the style. The orderly style lets the running divider period finish before stopping. The immediate style cuts the strobe on the next cycle.

The suspend-allow bit and the switch-off style bit are guarded. A write changes them only when a key bit is set in that same write. The key bit itself is never stored. All other fields of a write update normally.

Top module: `modclk_ctrl`

## Requirements
- R1: After reset, a read (rd_en high) returns 0 and mod_clk_en stays low.
- R2: With divisor N from 2 to 255 (bits 15:8), mod_clk_en is high for one cycle in every N. The first pulse comes N cycles after the cycle that wrote the divisor.
- R3: With divisor 1, mod_clk_en is high on every cycle from the cycle after the write.
- R4: With divisor 0, mod_clk_en stays low.
- R5: A write that changes the divisor restarts the period. The first pulse comes N cycles after that write, whatever the old count was.
- R6: Bit 2 (suspend allow) and bit 5 (fast stop) take the written value only when bit 4 is 1 in the same write. Bits 15:8 and bit 3 update on every write.
- R7: While rd_en is high, rd_data shows the stored fields at bits 2, 3, 5 and 15:8. Bit 4, bits 1:0, bits 7:6 and bits 31:16 always read 0.
- R8: With bit 3 = 0, a held sleep_req stops the pulses. With bit 3 = 1, sleep_req has no effect on the pulse pattern.
- R9: With bit 2 = 0, susp_req has no effect on the pulse pattern.
- R10: Orderly stop (sleep, or suspend with bit 5 = 0): the next pulse due after the request still appears, and mod_clk_en then stays low while the request is held.
- R11: Fast stop (suspend with bit 2 = 1 and bit 5 = 1): mod_clk_en is low from the cycle after susp_req is first seen high.
- R12: When the stopping request drops, mod_clk_en stays low for that cycle. Pulses then resume on the unchanged period from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Control word image, 0 when rd_en is low |
| sleep_req | input | 1 | Sleep request |
| susp_req | input | 1 | Debug suspend request |
| mod_clk_en | output | 1 | Peripheral clock-enable strobe |

## Verification
The divider is tried with several divisors:

- Divisors of 4 and 5 check the one-in-N spacing.
- Divisor 1 checks the always-high case.
- Divisor 0 checks the off state.
- Rewriting the divisor partway through a period shows whether the count restarts or carries the stale count forward.

Stop behaviour is driven with:

- Sleep while it is honoured and while it is disregarded.
- Suspend while it is not allowed.
- Suspend in both stop styles, with the request placed just before a due pulse. Whether that pulse appears separates the orderly stop from the fast stop.
- Release of each request, which shows that pulses resume on the original phase.

Writes with and without the key bit separate guarded fields from free ones.

// File: rtl/modclk_pkg.sv
// Package: shared field positions and the configuration record of the
// module clock controller. Assumes a 32-bit control word.
package modclk_pkg;
    localparam int DIV_W     = 8;
    localparam int DIV_LSB   = 8;
    localparam int BIT_SUSP  = 2;
    localparam int BIT_SLEEP = 3;
    localparam int BIT_KEY   = 4;
    localparam int BIT_FAST  = 5;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             fast_off;
        logic             sleep_dis;
        logic             susp_en;
    } cfg_t;
endpackage

// File: rtl/modclk_regs.sv
// Control register: stores divisor, sleep-disregard, suspend-allow and
// stop-style fields. Suspend-allow and stop-style change only when the
// key bit is set in the same write. Flags writes that change the divisor.
// Assumes DATA_W is at least DIV_LSB + DIV_W.
module modclk_regs
    import modclk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output cfg_t              cfg,
    output logic              div_load
);
    logic [DATA_W-1:0] img;
    logic [DIV_W-1:0]  new_div;
    logic              unused_bits;

    assign new_div     = wr_data[DIV_LSB +: DIV_W];
    assign unused_bits = ^{wr_data[1:0], wr_data[7:6], wr_data[DATA_W-1:DIV_LSB+DIV_W]};

    // Store fields; guarded bits follow the write only with the key set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.div       <= new_div;
            cfg.sleep_dis <= wr_data[BIT_SLEEP];
            if (wr_data[BIT_KEY]) begin
                cfg.susp_en  <= wr_data[BIT_SUSP];
                cfg.fast_off <= wr_data[BIT_FAST];
            end
        end
    end

    // Restart the divider whenever a write changes the divisor.
    always_comb div_load = wr_en && (new_div != cfg.div);

    // Build the read image; key and reserved bits are zero.
    always_comb begin
        img                       = '0;
        img[DIV_LSB +: DIV_W]     = cfg.div;
        img[BIT_SUSP]             = cfg.susp_en;
        img[BIT_SLEEP]            = cfg.sleep_dis;
        img[BIT_FAST]             = cfg.fast_off;
        rd_data                   = rd_en ? img : '0;
    end
endmodule

// File: rtl/modclk_div.sv
// Divider: counts 0..div-1 and flags the last count as a tick. A divisor
// of zero holds the count at zero with no tick. load restarts the count.
module modclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             load,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic             last;

    // Mark the final count of the period.
    always_comb begin
        last = (div != '0) && (cnt == div - ONE);
        tick = last;
    end

    // Advance, wrap, or restart the period count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load || (div == '0) || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end
endmodule

// File: rtl/modclk_gate.sv
// Gate: passes ticks unless a stop is in force. An orderly stop takes
// effect after the next tick has passed; a fast suspend stop takes effect
// one cycle after the request. Dropping the request clears the stop at
// the next edge.
module modclk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sleep_req,
    input  logic susp_req,
    input  logic sleep_dis,
    input  logic susp_en,
    input  logic fast_off,
    output logic en
);
    logic halted;
    logic stop_req;
    logic fast_path;

    // Decode which requests are honoured and which stop style applies.
    always_comb begin
        stop_req  = (sleep_req && !sleep_dis) || (susp_req && susp_en);
        fast_path = susp_req && susp_en && fast_off;
    end

    // Track the stopped state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (!stop_req) begin
            halted <= 1'b0;
        end else if (fast_path || tick) begin
            halted <= 1'b1;
        end
    end

    // Drive the strobe.
    always_comb en = tick && !halted;
endmodule

// File: rtl/modclk_ctrl.sv
// Top: peripheral module clock controller. Connects the control register,
// the divider and the stop gate. Assumes sleep_req and susp_req are
// synchronous to clk.
module modclk_ctrl
    import modclk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sleep_req,
    input  logic              susp_req,
    output logic              mod_clk_en
);
    cfg_t cfg;
    logic div_load;
    logic tick;

    modclk_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .cfg      (cfg),
        .div_load (div_load)
    );

    modclk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (cfg.div),
        .load  (div_load),
        .tick  (tick)
    );

    modclk_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sleep_req (sleep_req),
        .susp_req  (susp_req),
        .sleep_dis (cfg.sleep_dis),
        .susp_en   (cfg.susp_en),
        .fast_off  (cfg.fast_off),
        .en        (mod_clk_en)
    );
endmodule

// File: rtl/modclk_ctrl_chk.sv
// Checker: port-level properties of the module clock controller, bound
// to every instance of the top module.
module modclk_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_key,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic        sleep_req,
    input logic        susp_req,
    input logic        mod_clk_en
);
    // R7: reserved and key bits never read as 1.
    p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_data[31:16] == 16'h0) && (rd_data[7:6] == 2'b00)
                  && !rd_data[4] && (rd_data[1:0] == 2'b00));

    // R4: a zero divisor keeps the strobe low.
    p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && (rd_data[15:8] == 8'h00)) |-> !mod_clk_en);

    // R3: divisor 1 with no request gives a strobe on the next cycle.
    p_div1_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && (rd_data[15:8] == 8'h01) && !sleep_req && !susp_req)
        |=> mod_clk_en);

    // R6: a write without the key leaves the guarded bits unchanged.
    p_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && !wr_key)
        |=> (!rd_en || ((rd_data[2] == $past(rd_data[2]))
                        && (rd_data[5] == $past(rd_data[5])))));

    // R11: fast suspend silences the strobe one cycle after the request.
    p_fast_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_req && rd_en && !wr_en && rd_data[2] && rd_data[5])
        |=> !mod_clk_en);
endmodule

bind modclk_ctrl modclk_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_key     (wr_data[4]),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .sleep_req  (sleep_req),
    .susp_req   (susp_req),
    .mod_clk_en (mod_clk_en)
);

// File: tb/test_modclk_ctrl.sv
// Scoreboard bench: the driver pushes one expected item per cycle and a
// monitor at the falling edge pops and compares it.
module test_modclk_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        sleep_req = 1'b0;
    logic        susp_req = 1'b0;
    logic        mod_clk_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic sl_v = 1'b0;
    logic su_v = 1'b0;

    typedef struct {
        bit          chk_en;
        bit          exp_en;
        bit          chk_rd;
        logic [31:0] exp_rd;
        string       tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    modclk_ctrl i_modclk_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .sleep_req  (sleep_req),
        .susp_req   (susp_req),
        .mod_clk_en (mod_clk_en)
    );

    // Monitor: compare the outputs against the item for this cycle.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            if (it.chk_en) begin
                checks++;
                if (mod_clk_en !== it.exp_en) begin
                    failures++;
                    $display("FAIL %s: mod_clk_en=%b expected %b", it.tag, mod_clk_en, it.exp_en);
                end
            end
            if (it.chk_rd) begin
                checks++;
                if (rd_data !== it.exp_rd) begin
                    failures++;
                    $display("FAIL %s: rd_data=%h expected %h", it.tag, rd_data, it.exp_rd);
                end
            end
        end
    end

    // Drive one cycle of inputs and queue what the outputs must show.
    task automatic cyc(input logic we, input logic [31:0] wd, input logic re,
                       input bit ce, input bit ee, input bit cr,
                       input logic [31:0] er, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        wr_en = we;
        wr_data = wd;
        rd_en = re;
        sleep_req = sl_v;
        susp_req = su_v;
        it.chk_en = ce;
        it.exp_en = ee;
        it.chk_rd = cr;
        it.exp_rd = er;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [31:0] d);
        cyc(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, '0, "");
    endtask

    task automatic rd(input logic [31:0] e, input string tag);
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b1, e, tag);
    endtask

    task automatic en_is(input bit e, input string tag);
        cyc(1'b0, '0, 1'b0, 1'b1, e, 1'b0, '0, tag);
    endtask

    task automatic pulses(input int n, input int cnt, input string tag);
        for (int j = 1; j <= cnt; j++) en_is((j % n) == 0, tag);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        cyc(1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0, "R1");
        en_is(1'b0, "R1");
        en_is(1'b0, "R1");
        // R2: divisor 4
        cyc(1'b1, 32'h0000_0400, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R4");
        pulses(4, 12, "R2");
        // R3: divisor 1
        wr(32'h0000_0100);
        pulses(1, 6, "R3");
        // R4: divisor 0
        wr(32'h0000_0000);
        pulses(1000, 6, "R4");
        // R5: reload mid-period
        wr(32'h0000_0500);
        pulses(1000, 3, "R2");
        cyc(1'b1, 32'h0000_0300, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R2");
        pulses(3, 7, "R5");
        // R6 and R7: guarded bits and read image
        wr(32'hFFFF_FFEF);
        rd(32'h0000_FF08, "R6");
        wr(32'hFFFF_FFFF);
        rd(32'h0000_FF2C, "R7");
        wr(32'h0000_0310);
        rd(32'h0000_0300, "R6");
        wr(32'h0000_0324);
        rd(32'h0000_0300, "R6");
        // R8, R10, R12: honoured sleep
        wr(32'h0000_0200);
        en_is(1'b0, "R2");
        en_is(1'b1, "R2");
        sl_v = 1'b1;
        en_is(1'b0, "R8");
        en_is(1'b1, "R10");
        for (int j = 5; j <= 10; j++) en_is(1'b0, "R8");
        sl_v = 1'b0;
        en_is(1'b0, "R12");
        en_is(1'b1, "R12");
        en_is(1'b0, "R12");
        en_is(1'b1, "R12");
        // R8: sleep disregarded
        wr(32'h0000_0308);
        sl_v = 1'b1;
        pulses(3, 6, "R8");
        sl_v = 1'b0;
        // R9: suspend not allowed
        wr(32'h0000_0200);
        su_v = 1'b1;
        pulses(2, 6, "R9");
        su_v = 1'b0;
        // R11: fast suspend
        wr(32'h0000_0434);
        su_v = 1'b1;
        for (int j = 1; j <= 6; j++) en_is(1'b0, "R11");
        su_v = 1'b0;
        en_is(1'b0, "R12");
        en_is(1'b1, "R12");
        // R10: orderly suspend
        wr(32'h0000_0314);
        su_v = 1'b1;
        en_is(1'b0, "R10");
        en_is(1'b0, "R10");
        en_is(1'b1, "R10");
        for (int j = 4; j <= 7; j++) en_is(1'b0, "R10");
        su_v = 1'b0;
        en_is(1'b0, "R12");
        wait (sb.size() == 0);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule